// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block turns a pixel position in a surface of 32-bit pixels into the byte offset where that pixel lives in memory. It supports four layouts: plain row-major, a tile layout 512 bytes wide and 8 rows tall, a tile layout built from 16-byte column spans, and a tile layout 128 bytes wide that is split into permuted 64-byte subtiles. For the two older tiled layouts an optional XOR on address bit 6 can be applied. The XOR is driven by a selectable combination of bits 9, 10 and 11.

Requests arrive on a valid/ready stream that carries the coordinates, the row stride in bytes, the layout code and the swizzle code. Results leave on a valid/ready stream. The unit is a three-stage pipeline that accepts one request per cycle. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, every stage holds and `in_ready` is low. In every other cycle `in_ready` is high. A request is taken when `in_valid` and `in_ready` are both high at a clock edge. A result is consumed when `out_valid` and `out_ready` are both high. Results come out in request order.

Top module: `tile_addr_xlate`

## Requirements
- R1: Layout code 0 (row-major) gives offset = y*stride + 4*x, modulo 2^32, and never applies the bit-6 XOR.
- R2: Layout code 1 (512-byte by 8-row tiles), with b = 4*x, gives offset = (y/8)*stride*8 + (y%8)*512 + (b/512)*4096 + b%512 before the XOR.
- R3: Layout code 2 (16-byte column spans of 32 rows), with b = 4*x, gives offset = (y/32)*stride*32 + (y%32)*16 + (b/16)*512 + b%16 before the XOR.
- R4: Layout code 3 (128-byte by 32-row tiles) is computed from b = 4*x, tx = b%128 and ty = y%32. The subtile index s = (ty/4)*8 + tx/16 has its bits 2 and 3 exchanged to give p. The offset is (y/32)*stride*32 + (b/128)*4096 + p*64 + (ty%4)*16 + tx%16.
- R5: Layout code 3 never applies the bit-6 XOR, whatever the swizzle code.
- R6: For layout codes 1 and 2, bit 6 of the offset is XORed according to the swizzle code. Code 0 leaves it unchanged. Code 1 uses bit 9. Code 2 uses bits 9 and 10. Code 3 uses bits 9 and 11. Code 4 uses bits 9, 10 and 11. Codes 5 to 7 leave it unchanged.
- R7: `out_err` is high when the stride is not a multiple of the layout's alignment: 4 bytes for code 0, 512 for code 1, 128 for codes 2 and 3. The offset is still produced.
- R8: With `out_ready` held high, a result appears exactly 3 cycles after its request is accepted, and a new request can be accepted every cycle.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_offset` and `out_err` stay unchanged. No result is lost or reordered.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| in_stride | input | 16 | Row stride in bytes |
| in_mode | input | 2 | Layout code 0..3 |
| in_swz | input | 3 | Bit-6 swizzle code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_offset | output | 32 | Tiled byte offset |
| out_err | output | 1 | Stride misaligned for the layout |

## Verification
Two functions can fall in the same cycle. In the first, a stall from `out_ready` low coincides with a new request being offered. In the second, a result drains in the same edge as a request is accepted. The bench provokes both by streaming a near-exhaustive coordinate sweep over all layouts and swizzle codes while `out_ready` drops in a periodic pattern and in one longer burst. It judges them in two ways. Every consumed result must match, in order, an arithmetic model of the layout formulas. During every stalled cycle, `in_ready` must be low and the held output must not change.

// File: rtl/tax_pkg.sv
package tax_pkg;
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_XMAJ   = 2'd1,
    TM_YMAJ   = 2'd2,
    TM_FTILE  = 2'd3
  } tile_mode_e;

  // exchange bits 2 and 3 of the subtile index (self-inverse)
  function automatic logic [5:0] sub_perm(input logic [5:0] s);
    return {s[5:4], s[2], s[3], s[1:0]};
  endfunction

  // bit to fold into address bit 6 for a given swizzle code
  function automatic logic swz_term(input logic [2:0] code, input logic b9,
                                    input logic b10, input logic b11);
    case (code)
      3'd1:    return b9;
      3'd2:    return b9 ^ b10;
      3'd3:    return b9 ^ b11;
      3'd4:    return b9 ^ b10 ^ b11;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tax_decode.sv
module tax_decode
  import tax_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [SW-1:0] in_stride,
  input  logic [1:0]    in_mode,
  input  logic [2:0]    in_swz,
  output logic          s1_valid,
  output logic [CW-1:0] s1_major,
  output logic [2:0]    s1_shift,
  output logic [SW-1:0] s1_stride,
  output logic [OW-1:0] s1_addend,
  output logic [1:0]    s1_mode,
  output logic [2:0]    s1_swz,
  output logic          s1_err
);
  localparam int XBW = CW + 2;

  logic [XBW-1:0] xb;
  logic [CW-1:0]  major;
  logic [2:0]     shift;
  logic [OW-1:0]  addend;
  logic           err;
  logic [5:0]     sub_idx;
  tile_mode_e     mode;

  assign xb      = {in_x, 2'b00};
  assign mode    = tile_mode_e'(in_mode);
  assign sub_idx = {in_y[4:2], xb[6:4]};

  always_comb begin
    major  = in_y;
    shift  = 3'd0;
    addend = OW'(xb);
    err    = |in_stride[1:0];
    case (mode)
      TM_XMAJ: begin
        major  = in_y >> 3;
        shift  = 3'd3;
        addend = OW'({in_y[2:0], 9'd0}) + OW'({xb[XBW-1:9], 12'd0})
               + OW'(xb[8:0]);
        err    = |in_stride[8:0];
      end
      TM_YMAJ: begin
        major  = in_y >> 5;
        shift  = 3'd5;
        addend = OW'({in_y[4:0], 4'd0}) + OW'({xb[XBW-1:4], 9'd0})
               + OW'(xb[3:0]);
        err    = |in_stride[6:0];
      end
      TM_FTILE: begin
        major  = in_y >> 5;
        shift  = 3'd5;
        addend = OW'({xb[XBW-1:7], 12'd0}) + OW'({sub_perm(sub_idx), 6'd0})
               + OW'({in_y[1:0], 4'd0}) + OW'(xb[3:0]);
        err    = |in_stride[6:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_major  <= '0;
      s1_shift  <= '0;
      s1_stride <= '0;
      s1_addend <= '0;
      s1_mode   <= '0;
      s1_swz    <= '0;
      s1_err    <= 1'b0;
    end else if (en) begin
      s1_valid  <= in_valid;
      s1_major  <= major;
      s1_shift  <= shift;
      s1_stride <= in_stride;
      s1_addend <= addend;
      s1_mode   <= in_mode;
      s1_swz    <= in_swz;
      s1_err    <= err;
    end
  end
endmodule

// File: rtl/tax_muladd.sv
module tax_muladd #(
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          s1_valid,
  input  logic [CW-1:0] s1_major,
  input  logic [2:0]    s1_shift,
  input  logic [SW-1:0] s1_stride,
  input  logic [OW-1:0] s1_addend,
  input  logic [1:0]    s1_mode,
  input  logic [2:0]    s1_swz,
  input  logic          s1_err,
  output logic          s2_valid,
  output logic [OW-1:0] s2_off,
  output logic [1:0]    s2_mode,
  output logic [2:0]    s2_swz,
  output logic          s2_err
);
  logic [OW-1:0] prod;
  logic [OW-1:0] row_base;

  assign prod     = OW'(s1_major) * OW'(s1_stride);
  assign row_base = prod << s1_shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_off   <= '0;
      s2_mode  <= '0;
      s2_swz   <= '0;
      s2_err   <= 1'b0;
    end else if (en) begin
      s2_valid <= s1_valid;
      s2_off   <= row_base + s1_addend;
      s2_mode  <= s1_mode;
      s2_swz   <= s1_swz;
      s2_err   <= s1_err;
    end
  end
endmodule

// File: rtl/tax_swizzle.sv
module tax_swizzle
  import tax_pkg::*;
#(
  parameter int OW     = 32,
  parameter bit SWZ_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          s2_valid,
  input  logic [OW-1:0] s2_off,
  input  logic [1:0]    s2_mode,
  input  logic [2:0]    s2_swz,
  input  logic          s2_err,
  output logic          out_valid,
  output logic [OW-1:0] out_offset,
  output logic          out_err
);
  logic [OW-1:0] swz_off;

  generate
    if (SWZ_EN) begin : g_swz
      logic apply;
      logic flip;
      assign apply = (tile_mode_e'(s2_mode) == TM_XMAJ) ||
                     (tile_mode_e'(s2_mode) == TM_YMAJ);
      assign flip  = apply & swz_term(s2_swz, s2_off[9], s2_off[10], s2_off[11]);
      assign swz_off = {s2_off[OW-1:7], s2_off[6] ^ flip, s2_off[5:0]};
    end else begin : g_noswz
      logic [2:0] unused_swz;
      logic [1:0] unused_mode;
      assign unused_swz  = s2_swz;
      assign unused_mode = s2_mode;
      assign swz_off     = s2_off;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else if (en) begin
      out_valid  <= s2_valid;
      out_offset <= swz_off;
      out_err    <= s2_err;
    end
  end
endmodule

// File: rtl/tile_addr_xlate.sv
module tile_addr_xlate #(
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [SW-1:0] in_stride,
  input  logic [1:0]    in_mode,
  input  logic [2:0]    in_swz,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_offset,
  output logic          out_err
);
  logic          en;
  logic          s1_valid, s1_err, s2_valid, s2_err;
  logic [CW-1:0] s1_major;
  logic [2:0]    s1_shift, s1_swz, s2_swz;
  logic [SW-1:0] s1_stride;
  logic [OW-1:0] s1_addend, s2_off;
  logic [1:0]    s1_mode, s2_mode;

  // whole pipe advances unless a result is waiting on a stalled consumer
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  tax_decode #(.CW(CW), .SW(SW), .OW(OW)) u_dec (
    .clk, .rst_n, .en, .in_valid, .in_x, .in_y, .in_stride, .in_mode, .in_swz,
    .s1_valid, .s1_major, .s1_shift, .s1_stride, .s1_addend, .s1_mode,
    .s1_swz, .s1_err
  );

  tax_muladd #(.CW(CW), .SW(SW), .OW(OW)) u_mac (
    .clk, .rst_n, .en, .s1_valid, .s1_major, .s1_shift, .s1_stride,
    .s1_addend, .s1_mode, .s1_swz, .s1_err,
    .s2_valid, .s2_off, .s2_mode, .s2_swz, .s2_err
  );

  tax_swizzle #(.OW(OW), .SWZ_EN(1'b1)) u_swz (
    .clk, .rst_n, .en, .s2_valid, .s2_off, .s2_mode, .s2_swz, .s2_err,
    .out_valid, .out_offset, .out_err
  );
endmodule

// File: rtl/tax_checker.sv
module tax_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_x,
  input logic [15:0] in_y,
  input logic [15:0] in_stride,
  input logic [1:0]  in_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_offset,
  input logic        out_err
);
  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_err))); // R9

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
    |-> out_valid); // R8

  AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1)
     && $past(in_mode, 3) == 2'd0)
    |-> out_offset == ($past({16'd0, in_y}, 3) * $past({16'd0, in_stride}, 3)
                       + $past({14'd0, in_x, 2'b00}, 3))); // R1

  AST_XALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1)
     && $past(in_mode, 3) == 2'd1)
    |-> out_err == ($past(in_stride, 3) % 16'd512 != 16'd0)); // R7
endmodule

bind tile_addr_xlate tax_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_x(in_x), .in_y(in_y), .in_stride(in_stride), .in_mode(in_mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
  .out_err(out_err)
);

// File: tb/sim_tile_addr_xlate.sv
`timescale 1ns/1ps
module sim_tile_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_x = '0, in_y = '0, in_stride = '0;
  logic [1:0]  in_mode = '0;
  logic [2:0]  in_swz = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_offset;
  logic        out_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tile_addr_xlate u0 (.*);

  localparam int MAXV = 6000;
  logic [15:0] vx [MAXV];
  logic [15:0] vy [MAXV];
  logic [15:0] vs [MAXV];
  logic [1:0]  vm [MAXV];
  logic [2:0]  vz [MAXV];
  int nv = 0;

  logic [32:0] expq [$];
  logic [1:0]  modeq [$];

  function automatic logic [31:0] ref_off(input longint x, input longint y,
      input longint s, input int mode, input int swz);
    longint b, v, tx, ty, sub, b2, b3, p;
    logic [31:0] r;
    logic f;
    b = x * 4;
    case (mode)
      0: v = y * s + b;                                                     // R1
      1: v = (y/8)*s*8 + (y%8)*512 + (b/512)*4096 + b%512;                  // R2
      2: v = (y/32)*s*32 + (y%32)*16 + (b/16)*512 + b%16;                   // R3
      default: begin                                                        // R4
        tx = b % 128; ty = y % 32;
        sub = (ty/4)*8 + tx/16;
        b2 = (sub/4)%2; b3 = (sub/8)%2;
        p = sub - b2*4 - b3*8 + b2*8 + b3*4;
        v = (y/32)*s*32 + (b/128)*4096 + p*64 + (ty%4)*16 + tx%16;
      end
    endcase
    r = v[31:0];
    f = 1'b0;
    if (mode == 1 || mode == 2) begin                                       // R6, R5
      case (swz)
        1: f = r[9];
        2: f = r[9] ^ r[10];
        3: f = r[9] ^ r[11];
        4: f = r[9] ^ r[10] ^ r[11];
        default: f = 1'b0;
      endcase
    end
    r[6] = r[6] ^ f;
    return r;
  endfunction

  function automatic logic ref_err(input int s, input int mode);            // R7
    case (mode)
      0: return (s % 4) != 0;
      1: return (s % 512) != 0;
      default: return (s % 128) != 0;
    endcase
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    summary();
  end

  initial begin
    int cyc, lat, i;
    logic stall_prev;
    logic [31:0] held_off;
    logic held_err;
    logic [32:0] e;
    logic [1:0] em;
    string tag;

    // build vectors: sweep of layouts, coordinates and swizzle codes
    for (int m = 0; m < 4; m++)
      for (int y = 0; y < 40; y++)
        for (int x = 0; x < 200; x += 7) begin
          vx[nv] = 16'(x); vy[nv] = 16'(y);
          vs[nv] = (y % 3 == 0) ? 16'd2048 : 16'd1024;
          vm[nv] = 2'(m); vz[nv] = 3'((x + y) % 8);
          nv++;
        end
    for (int k = 0; k < 64; k++) begin  // misaligned strides (R7)
      vx[nv] = 16'(k * 37); vy[nv] = 16'((k * 5) % 70);
      vs[nv] = 16'(1000 + k * 3); vm[nv] = 2'(k % 4); vz[nv] = 3'(k % 5);
      nv++;
    end
    for (int m = 0; m < 4; m++) begin  // extreme coordinates, wrap modulo 2^32
      vx[nv] = 16'hFFFF; vy[nv] = 16'hFFFF; vs[nv] = 16'hFF80;
      vm[nv] = 2'(m); vz[nv] = 3'd4; nv++;
    end

    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 0);
    check(in_ready == 1'b0 || in_ready == 1'b1, "R10 in_ready known", 64'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10 idle after reset", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 1);

    // R8: latency of a single request with the consumer always ready
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_x = 16'd5; in_y = 16'd9; in_stride = 16'd1024; in_mode = 2'd1; in_swz = 3'd0;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin @(negedge clk); lat++; end
    check(lat == 3, "R8 latency", 64'(lat), 3);
    check(out_offset == ref_off(5, 9, 1024, 1, 0), "R2 single", 64'(out_offset),
          64'(ref_off(5, 9, 1024, 1, 0)));
    @(negedge clk);

    // stream with periodic and burst back-pressure (R8, R9)
    i = 0; cyc = 0; stall_prev = 1'b0; held_off = '0; held_err = 1'b0;
    while (!(i >= nv && expq.size() == 0)) begin
      out_ready = !((cyc % 7) == 5 || (cyc >= 2000 && cyc < 2006));
      if (i < nv) begin
        in_valid = 1'b1; in_x = vx[i]; in_y = vy[i]; in_stride = vs[i];
        in_mode = vm[i]; in_swz = vz[i];
      end else in_valid = 1'b0;
      #1;
      if (stall_prev) begin
        check(out_valid && out_offset == held_off && out_err == held_err,
              "R9 held output", {31'd0, out_err, out_offset}, {31'd0, held_err, held_off});
      end
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R9 in_ready during stall", 64'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected result", 64'(out_offset), 0);
        end else begin
          e = expq.pop_front(); em = modeq.pop_front();
          case (em)
            2'd0: tag = "R1";
            2'd1: tag = "R2 R6";
            2'd2: tag = "R3 R6";
            default: tag = "R4 R5";
          endcase
          check(out_offset == e[31:0], tag, 64'(out_offset), 64'(e[31:0]));
          check(out_err == e[32], "R7 err flag", 64'(out_err), 64'(e[32]));
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back({ref_err(int'(in_stride), int'(in_mode)),
                        ref_off(in_x, in_y, in_stride, int'(in_mode), int'(in_swz))});
        modeq.push_back(in_mode);
        i++;
      end
      stall_prev = out_valid && !out_ready;
      held_off = out_offset; held_err = out_err;
      cyc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    summary();
  end
endmodule